// File: doc/BRIEF.md
# Interrupt request controller

This block gathers interrupt requests from nine sources of a small microcontroller: two external pins, three timers, two serial ports, an I2C port and a USB port. It keeps one request flag per source. It picks the pending, enabled request with the highest priority and presents it to the CPU core as a request line, a source index and a vector address. When the core acknowledges the vector, the winning flag is cleared or kept according to the rule for that source.

The rules differ by source. An external pin in edge mode, the timers 0 and 1, I2C and an ADC-done event (when it has taken over the second pin's slot) are cleared on vectoring. An external pin in level mode has a flag that simply follows the pin. Timer 2, USB and both serial ports keep their flags until software clears them. After an acknowledge no further request is raised until the core signals the end of the routine.

Top module: `irq_hub`

## Requirements
- R1: While reset is low, and on leaving reset, every flag, `t2_ext_flag` and `irq` are 0.
- R2: With `ext0_edge`=0 (level mode, active low), `flags[0]` equals the inverse of `ext0_n` two clocks after the pin changes. It is not cleared by an acknowledge. If the pin is still low when `reti` arrives, `irq` is raised again. The same rule applies to `ext1_n`/`flags[4]` when `ext1_edge`=0 and `adc_sel`=0.
- R3: With `ext0_edge`=1, a high sample followed by a low sample of `ext0_n` on consecutive clocks sets `flags[0]` two clocks after the pin falls. Acknowledging that request clears the flag.
- R4: A pulse on `tmr0_ovf`, `i2c_evt` or `tmr1_ovf` sets `flags[2]`, `flags[3]` or `flags[5]` one clock later. The flag is cleared when its request is acknowledged, or by the matching `sw_clr` bit.
- R5: `tmr2_ovf` sets `flags[8]`. `t2_strobe` sets `t2_ext_flag` only while `t2_strobe_en`=1. Either flag raises request slot 8. Neither is cleared by an acknowledge: only `sw_clr[8]` and `t2x_clr` clear them.
- R6: Any bit of `usb_evt` sets `flags[6]`. `usart2_evt` sets `flags[1]` and `usart_evt` sets `flags[7]`. These three flags are cleared only by their `sw_clr` bits.
- R7: With `adc_sel`=1, slot 4 is set by `adc_done`, `ext1_n` has no effect on it, and it is cleared on acknowledge.
- R8: `irq` is 1 exactly when `global_en`=1, no routine is in progress, and some slot has both its request and its `src_en` bit set.
- R9: Among requesting, enabled slots the lowest index wins. `irq_idx` gives that index (0 when none). `irq_vec` = 0x0003 + 8 × `irq_idx`.
- R10: `ack` while `irq`=1 starts a routine, and `irq` stays 0 until `reti`. `ack` while `irq`=0 has no effect.
- R11: If a set event and a clear hit the same flag in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext0_n | input | 1 | External pin 0, active low |
| ext1_n | input | 1 | External pin 1, active low |
| ext0_edge | input | 1 | Pin 0 mode: 1 falling edge, 0 low level |
| ext1_edge | input | 1 | Pin 1 mode: 1 falling edge, 0 low level |
| adc_sel | input | 1 | 1: ADC-done drives slot 4 instead of pin 1 |
| adc_done | input | 1 | ADC conversion-complete pulse |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| t2_strobe | input | 1 | Timer 2 external capture/reload strobe |
| t2_strobe_en | input | 1 | Lets `t2_strobe` set the external flag |
| usart_evt | input | 1 | Serial port event pulse |
| usart2_evt | input | 1 | Second serial port event pulse |
| i2c_evt | input | 1 | I2C event pulse |
| usb_evt | input | 7 | USB events: ep0 tx, ep0 rx, ep1 tx, ep2 tx, suspend, resume, end of packet |
| src_en | input | 9 | Per-slot enable |
| global_en | input | 1 | Global enable |
| sw_clr | input | 9 | Software clear strobe per flag |
| t2x_clr | input | 1 | Software clear of the timer 2 external flag |
| ack | input | 1 | Vector acknowledge from the core |
| reti | input | 1 | End-of-routine strobe from the core |
| irq | output | 1 | Interrupt request to the core |
| irq_idx | output | 4 | Winning slot index |
| irq_vec | output | 16 | Vector address of the winning slot |
| flags | output | 9 | Request flags by slot |
| t2_ext_flag | output | 1 | Timer 2 external flag |

## Verification
The hardest case to reach is a level-mode pin that is still held low when the routine ends. It must raise a fresh request only after `reti`, and never between `ack` and `reti`. The stimulus holds the pin low across a complete acknowledge and return, and checks that `irq` is low during the routine and high again afterwards. Collisions between a set and a clear in one clock are produced by driving an overflow pulse in the same cycle as its software clear. A cycle-by-cycle model also compares every output on each clock.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int VEC_SHIFT = 3,
  parameter int USB_EVTS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext0_n,
  input  logic                ext1_n,
  input  logic                ext0_edge,
  input  logic                ext1_edge,
  input  logic                adc_sel,
  input  logic                adc_done,
  input  logic                tmr0_ovf,
  input  logic                tmr1_ovf,
  input  logic                tmr2_ovf,
  input  logic                t2_strobe,
  input  logic                t2_strobe_en,
  input  logic                usart_evt,
  input  logic                usart2_evt,
  input  logic                i2c_evt,
  input  logic [USB_EVTS-1:0] usb_evt,
  input  logic [8:0]          src_en,
  input  logic                global_en,
  input  logic [8:0]          sw_clr,
  input  logic                t2x_clr,
  input  logic                ack,
  input  logic                reti,
  output logic                irq,
  output logic [3:0]          irq_idx,
  output logic [15:0]         irq_vec,
  output logic [8:0]          flags,
  output logic                t2_ext_flag
);
  localparam int NSRC = 9;
  localparam int IW = $clog2(NSRC);

  logic [1:0] s0, s1;
  logic [NSRC-1:0] flg, set, clr, nxt, req, auto_clr;
  logic t2x, busy, take;
  logic [IW-1:0] win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s0 <= 2'b11;
      s1 <= 2'b11;
    end else begin
      s0 <= {s0[0], ext0_n};
      s1 <= {s1[0], ext1_n};
    end

  assign set = {tmr2_ovf, usart_evt, |usb_evt, tmr1_ovf,
                adc_sel ? adc_done : (s1[1] & ~s1[0]),
                i2c_evt, tmr0_ovf, usart2_evt, s0[1] & ~s0[0]};
  assign auto_clr = {3'b000, 1'b1, adc_sel | ext1_edge, 2'b11, 1'b0, ext0_edge};
  assign req = (flg | {t2x, {(NSRC-1){1'b0}}}) & src_en;

  always_comb begin
    win = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (req[i]) win = IW'(i);
  end

  assign irq  = global_en & ~busy & (|req);
  assign take = ack & irq;
  assign clr  = sw_clr | (take ? (auto_clr & (NSRC'(1) << win)) : '0);

  always_comb begin
    nxt = set | (flg & ~clr);
    if (!ext0_edge) nxt[0] = ~s0[0];
    if (!adc_sel && !ext1_edge) nxt[4] = ~s1[0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flg  <= '0;
      t2x  <= 1'b0;
      busy <= 1'b0;
    end else begin
      flg <= nxt;
      t2x <= (t2_strobe & t2_strobe_en) | (t2x & ~t2x_clr);
      if (take) busy <= 1'b1;
      else if (reti) busy <= 1'b0;
    end

  assign irq_idx     = 4'(win);
  assign irq_vec     = VEC_BASE + (16'(win) << VEC_SHIFT);
  assign flags       = flg;
  assign t2_ext_flag = t2x;
endmodule

module irq_hub_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       reti,
  input logic       irq,
  input logic [3:0] irq_idx,
  input logic [8:0] flags,
  input logic [8:0] src_en,
  input logic [8:0] sw_clr,
  input logic       global_en,
  input logic       tmr0_ovf,
  input logic       adc_sel,
  input logic       adc_done
);
  assert_reset_clean_R1: assert property (@(posedge clk)
    !rst_n |=> (flags == 9'd0 && !irq));

  assert_tmr0_hw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && irq_idx == 4'd2 && !tmr0_ovf) |=> !flags[2]);

  assert_tmr2_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && flags[8] && !sw_clr[8]) |=> flags[8]);

  assert_usb_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[6] && !sw_clr[6]) |=> flags[6]);

  assert_adc_owns_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel && !adc_done && !flags[4]) |=> !flags[4]);

  assert_global_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !global_en |-> !irq);

  assert_pin0_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && flags[0] && src_en[0]) |-> irq_idx == 4'd0);

  assert_no_nesting_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !reti) |=> !irq);
endmodule

bind irq_hub irq_hub_chk u_chk (.*);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext0_n = 1, ext1_n = 1, ext0_edge = 1, ext1_edge = 1, adc_sel = 0, adc_done = 0;
  logic tmr0_ovf = 0, tmr1_ovf = 0, tmr2_ovf = 0, t2_strobe = 0, t2_strobe_en = 0;
  logic usart_evt = 0, usart2_evt = 0, i2c_evt = 0;
  logic [6:0] usb_evt = '0;
  logic [8:0] src_en = '1, sw_clr = '0;
  logic global_en = 1, t2x_clr = 0, ack = 0, reti = 0;
  logic irq, t2_ext_flag;
  logic [3:0] irq_idx;
  logic [15:0] irq_vec;
  logic [8:0] flags;

  int checks = 0, fails = 0;
  string cur = "R1";

  always #2 clk = ~clk;

  irq_hub u_irq_hub (.*);

  // behavioural reference model
  bit [8:0] m_f = '0;
  bit m_t2x = 0, m_busy = 0, m_p0n = 1, m_p0o = 1, m_p1n = 1, m_p1o = 1;
  bit [8:0] e_req;
  int e_win;
  bit e_irq;

  always_comb begin
    e_req = (m_f | (9'(m_t2x) << 8)) & src_en;
    e_win = 0;
    for (int i = 8; i >= 0; i--) if (e_req[i]) e_win = i;
    e_irq = global_en && !m_busy && (e_req != 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_f = '0; m_t2x = 0; m_busy = 0;
      m_p0n = 1; m_p0o = 1; m_p1n = 1; m_p1o = 1;
    end else begin
      bit tk, f0, f1, h4;
      bit [8:0] f, n;
      int w;
      tk = ack && e_irq; w = e_win; f = m_f;
      f0 = m_p0o && !m_p0n; f1 = m_p1o && !m_p1n;
      n[0] = ext0_edge ? (f0 || (f[0] && !sw_clr[0] && !(tk && w == 0))) : !m_p0n;
      n[1] = usart2_evt || (f[1] && !sw_clr[1]);
      n[2] = tmr0_ovf || (f[2] && !sw_clr[2] && !(tk && w == 2));
      n[3] = i2c_evt || (f[3] && !sw_clr[3] && !(tk && w == 3));
      h4 = f[4] && !sw_clr[4] && !(tk && w == 4);
      if (adc_sel) n[4] = adc_done || h4;
      else if (ext1_edge) n[4] = f1 || h4;
      else n[4] = !m_p1n;
      n[5] = tmr1_ovf || (f[5] && !sw_clr[5] && !(tk && w == 5));
      n[6] = (usb_evt != 0) || (f[6] && !sw_clr[6]);
      n[7] = usart_evt || (f[7] && !sw_clr[7]);
      n[8] = tmr2_ovf || (f[8] && !sw_clr[8]);
      m_f = n;
      m_t2x = (t2_strobe && t2_strobe_en) || (m_t2x && !t2x_clr);
      if (tk) m_busy = 1; else if (reti) m_busy = 0;
      m_p0o = m_p0n; m_p0n = ext0_n; m_p1o = m_p1n; m_p1n = ext1_n;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      chk({cur, " irq"}, 32'(irq), 32'(e_irq));
      chk({cur, " idx"}, 32'(irq_idx), 32'(e_win));
      chk({cur, " vec"}, 32'(irq_vec), 32'(3 + 8 * e_win));
      chk({cur, " flags"}, 32'(flags), 32'(m_f));
      chk({cur, " t2x"}, 32'(t2_ext_flag), 32'(m_t2x));
    end
  endtask

  task automatic service();
    ack = 1; tick(1); ack = 0;
    reti = 1; tick(1); reti = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    cur = "R1";
    tick(2);
    chk("R1 reset flags", 32'(flags), 0);
    chk("R1 reset irq", 32'(irq), 0);
    rst_n = 1; tick(2);
    chk("R1 idle irq", 32'(irq), 0);

    cur = "R3";
    ext0_n = 0; tick(1); ext0_n = 1; tick(1);
    chk("R3 edge flag", 32'(flags[0]), 1);
    chk("R3 idx", 32'(irq_idx), 0);
    chk("R9 vec slot0", 32'(irq_vec), 3);
    ack = 1; tick(1); ack = 0;
    chk("R3 cleared on ack", 32'(flags[0]), 0);
    chk("R10 busy", 32'(irq), 0);
    reti = 1; tick(1); reti = 0;

    cur = "R2";
    ext0_edge = 0; tick(2);
    ext0_n = 0; tick(2);
    chk("R2 level flag", 32'(flags[0]), 1);
    ack = 1; tick(1); ack = 0;
    chk("R2 kept on ack", 32'(flags[0]), 1);
    chk("R10 no irq in routine", 32'(irq), 0);
    tick(2);
    chk("R10 still blocked", 32'(irq), 0);
    reti = 1; tick(1); reti = 0;
    chk("R2 re-request", 32'(irq), 1);
    ext0_n = 1; tick(2);
    chk("R2 follows pin", 32'(flags[0]), 0);
    chk("R2 irq drop", 32'(irq), 0);
    ext1_edge = 0; ext1_n = 0; tick(2);
    chk("R2 pin1 level", 32'(flags[4]), 1);
    ext1_n = 1; tick(2);
    chk("R2 pin1 release", 32'(flags[4]), 0);
    ext1_edge = 1; ext0_edge = 1; tick(2);

    cur = "R10";
    ack = 1; tick(1); ack = 0;
    tmr0_ovf = 1; tick(1); tmr0_ovf = 0;
    chk("R10 stray ack ignored", 32'(irq), 1);
    service();

    cur = "R4";
    tmr0_ovf = 1; i2c_evt = 1; tmr1_ovf = 1; tick(1);
    tmr0_ovf = 0; i2c_evt = 0; tmr1_ovf = 0;
    chk("R9 idx timer0", 32'(irq_idx), 2);
    chk("R9 vec timer0", 32'(irq_vec), 19);
    service();
    chk("R4 t0 cleared", 32'(flags[2]), 0);
    chk("R9 vec i2c", 32'(irq_vec), 27);
    service();
    chk("R9 vec timer1", 32'(irq_vec), 43);
    service();
    chk("R4 all cleared", 32'(flags), 0);

    cur = "R11";
    tmr0_ovf = 1; sw_clr = 9'h004; tick(1); tmr0_ovf = 0; sw_clr = 0;
    chk("R11 set wins", 32'(flags[2]), 1);
    sw_clr = 9'h004; tick(1); sw_clr = 0;
    chk("R4 sw clear", 32'(flags[2]), 0);

    cur = "R8";
    tmr0_ovf = 1; global_en = 0; tick(1); tmr0_ovf = 0;
    chk("R8 global mask", 32'(irq), 0);
    global_en = 1; src_en = 9'h1FB; tick(1);
    chk("R8 source mask", 32'(irq), 0);
    chk("R8 flag held", 32'(flags[2]), 1);
    src_en = '1; tick(1);
    chk("R8 unmasked", 32'(irq), 1);
    service();

    cur = "R5";
    t2_strobe = 1; tick(1); t2_strobe = 0;
    chk("R5 strobe gated", 32'(t2_ext_flag), 0);
    t2_strobe_en = 1; t2_strobe = 1; tick(1); t2_strobe = 0;
    chk("R5 strobe flag", 32'(t2_ext_flag), 1);
    chk("R9 vec timer2", 32'(irq_vec), 67);
    tmr2_ovf = 1; tick(1); tmr2_ovf = 0;
    service();
    chk("R5 ovf kept", 32'(flags[8]), 1);
    chk("R5 ext kept", 32'(t2_ext_flag), 1);
    sw_clr = 9'h100; tick(1); sw_clr = 0;
    chk("R5 ovf cleared", 32'(flags[8]), 0);
    chk("R5 ext still requests", 32'(irq), 1);
    t2x_clr = 1; tick(1); t2x_clr = 0;
    chk("R5 all clear", 32'(irq), 0);

    cur = "R6";
    for (int b = 0; b < 7; b++) begin
      usb_evt = 7'(1 << b); tick(1); usb_evt = 0;
      chk("R6 usb set", 32'(flags[6]), 1);
      service();
      chk("R6 usb kept", 32'(flags[6]), 1);
      sw_clr = 9'h040; tick(1); sw_clr = 0;
      chk("R6 usb cleared", 32'(flags[6]), 0);
    end
    usart_evt = 1; usart2_evt = 1; tick(1); usart_evt = 0; usart2_evt = 0;
    chk("R9 usart2 first", 32'(irq_idx), 1);
    service();
    chk("R6 usart2 kept", 32'(irq_idx), 1);
    sw_clr = 9'h082; tick(1); sw_clr = 0;
    chk("R6 serial cleared", 32'(irq), 0);

    cur = "R7";
    adc_sel = 1; ext1_edge = 0; ext1_n = 0; tick(3);
    chk("R7 pin ignored", 32'(flags[4]), 0);
    adc_done = 1; tick(1); adc_done = 0;
    chk("R7 adc set", 32'(flags[4]), 1);
    chk("R9 vec slot4", 32'(irq_vec), 35);
    service();
    chk("R7 adc cleared", 32'(flags[4]), 0);
    ext1_n = 1; adc_sel = 0; tick(3);
    finish_run();
  end
endmodule